// File: doc/BRIEF.md
# Bit-Field I/O Bank Access Unit

This unit gives a small controller access to bit fields that lie inside two byte-wide I/O banks, one called left and one called right. Each bank has its own 8-bit address register. A field access first reads the addressed byte from an external 9-bit I/O bus and latches it. A field read then returns the selected bits, right-justified. A field write merges a right-justified value into the latched byte and writes the merged byte back to the same address. Bits outside the field keep the values that were just read.

Each request carries four items: the bank, a 3-bit length code, a 3-bit position code and a data byte. The position code counts bit numbers downward from the most significant bit. A field's lowest bit sits at byte bit `7 - pos`, and the field extends upward from that bit. The unit accepts a request only while `busy` is low. Setting a bank address involves no bus traffic. Each field access uses the bus for one cycle (read) or two cycles (read then write).

Top module: `bitfield_iv_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `io_rd`, `io_wr` and `rd_valid` are 0 and `io_addr` is 0. Both bank address registers reset to 0.
- R2: A request with `req_kind` = 0 is accepted while `busy` is low. It loads `req_data` into the address register of bank `req_bank` (0 = left, 1 = right). It causes no bus strobe and does not raise `busy`. Later accesses drive `io_addr` = {0, left register} for the left bank and {1, right register} for the right bank.
- R3: A request with `req_kind` = 1 (field read) or 2 (field write), accepted while `busy` is low, raises `io_rd` and `busy` for exactly the next cycle, with the bank address on `io_addr`.
- R4: One cycle after the read strobe of a field read, `rd_valid` pulses for one cycle. `rd_field` then equals the byte read, rotated right by `7 - pos` and masked to the field width. The width is `req_len`, except that code 0 means 8.
- R5: A field write has no `rd_valid`. Its read strobe is followed in the next cycle by a one-cycle `io_wr` at the same `io_addr`, and `busy` stays high through both cycles.
- R6: The byte written equals (B & ~M) | ((V << (7-pos)) & M). Here B is the byte read, V is `req_data`, and M is the width mask shifted left by `7 - pos`, truncated to 8 bits.
- R7: Requests presented while `busy` is high are ignored, including address loads.
- R8: A request with `req_kind` = 3 is ignored: there is no strobe, `busy` stays low and no register changes.
- R9: `io_rd` and `io_wr` are never high together, and `io_addr` is 0 whenever neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 load address, 1 field read, 2 field write, 3 none |
| req_bank | input | 1 | 0 left bank, 1 right bank |
| req_len | input | 3 | Field length code, 0 means 8 bits |
| req_pos | input | 3 | Position code; field low bit is byte bit 7-pos |
| req_data | input | 8 | Address value or right-justified field value |
| busy | output | 1 | Bus access in progress |
| rd_valid | output | 1 | Field read result valid |
| rd_field | output | 8 | Right-justified field read result |
| io_addr | output | 9 | I/O bus address, bit 8 selects the right bank |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data, valid in the read strobe cycle |

## Verification
The assertions assume that `io_rdata` is valid in the same cycle as `io_rd`. They also assume that the requester does not rely on a request taken while `busy` is high. They only relate strobes, `busy` and the request handshake, so the value of `io_rdata` does not matter to them. The bench models the bus as a combinational 512-byte memory indexed by `io_addr`, so read data is always valid in the strobe cycle. Its random phase presents requests in every cycle, including busy ones, so the ignore rules are exercised.

// File: rtl/bitfield_iv_unit.sv
module bitfield_iv_unit #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_bank,
  input  logic [LW-1:0] req_len,
  input  logic [LW-1:0] req_pos,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_field,
  output logic [DW:0]   io_addr,
  output logic          io_rd,
  output logic          io_wr,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata
);
  localparam logic [LW-1:0] TOP = LW'(DW - 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;
  state_t state;

  logic [DW-1:0] addr_l, addr_r, lat_l, lat_r, op_val;
  logic [LW-1:0] op_len, op_pos;
  logic          op_bank, op_wr;

  wire take = req_valid && (state == S_IDLE);

  wire [LW-1:0]   sh     = TOP - op_pos;
  wire [DW-1:0]   fmask  = (op_len == '0) ? {DW{1'b1}} : DW'((DW'(1) << op_len) - 1'b1);
  wire [2*DW-1:0] dbl    = {io_rdata, io_rdata} >> sh;
  wire [DW-1:0]   fext   = dbl[DW-1:0] & fmask;
  wire [DW-1:0]   msk_sh = fmask << sh;
  wire [DW-1:0]   val_sh = op_val << sh;
  wire [DW-1:0]   merged = (io_rdata & ~msk_sh) | (val_sh & msk_sh);

  assign busy     = (state != S_IDLE);
  assign io_rd    = (state == S_RD);
  assign io_wr    = (state == S_WR);
  assign io_addr  = busy ? {op_bank, (op_bank ? addr_r : addr_l)} : '0;
  assign io_wdata = op_bank ? lat_r : lat_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_l   <= '0;
      addr_r   <= '0;
      lat_l    <= '0;
      lat_r    <= '0;
      op_bank  <= 1'b0;
      op_wr    <= 1'b0;
      op_len   <= '0;
      op_pos   <= '0;
      op_val   <= '0;
      rd_valid <= 1'b0;
      rd_field <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (take) begin
          if (req_kind == 2'd0) begin
            if (req_bank) addr_r <= req_data;
            else          addr_l <= req_data;
          end else if (req_kind != 2'd3) begin
            state   <= S_RD;
            op_bank <= req_bank;
            op_wr   <= (req_kind == 2'd2);
            op_len  <= req_len;
            op_pos  <= req_pos;
            op_val  <= req_data;
          end
        end
        S_RD: begin
          if (op_bank) lat_r <= op_wr ? merged : io_rdata;
          else         lat_l <= op_wr ? merged : io_rdata;
          if (op_wr) begin
            state <= S_WR;
          end else begin
            state    <= S_IDLE;
            rd_valid <= 1'b1;
            rd_field <= fext;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitfield_iv_checker.sv
module bitfield_iv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       busy,
  input logic       rd_valid,
  input logic [8:0] io_addr,
  input logic       io_rd,
  input logic       io_wr
);
  wire acc = req_valid && !busy;

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));
  a_r9_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd || io_wr) |-> io_addr == 9'd0);
  a_r3_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_kind == 2'd1 || req_kind == 2'd2)) |=> (io_rd && busy));
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> ($past(io_rd) && io_addr == $past(io_addr) && busy));
  a_r4_result_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(io_rd) && !io_wr));
  a_r2_addr_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd0) |=> (!io_rd && !io_wr && !busy));
  a_r8_kind3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd3) |=> !busy);
endmodule

bind bitfield_iv_unit bitfield_iv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .busy(busy), .rd_valid(rd_valid), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr)
);

// File: tb/tb_bitfield_iv_unit.sv
`timescale 1ns/1ps
module tb_bitfield_iv_unit;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_bank = 0;
  logic [1:0] req_kind = 0;
  logic [2:0] req_len = 0, req_pos = 0;
  logic [7:0] req_data = 0;
  logic busy, rd_valid, io_rd, io_wr;
  logic [7:0] rd_field, io_wdata, io_rdata;
  logic [8:0] io_addr;
  logic [7:0] mem [512];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bitfield_iv_unit dut (.*);

  assign io_rdata = mem[io_addr];
  always @(posedge clk) if (io_wr) mem[io_addr] <= io_wdata;

  // behavioural reference model
  int ph = 0;
  logic m_bank, m_wr, m_rdv;
  logic [2:0] m_len, m_pos;
  logic [7:0] m_val, m_ivl, m_ivr, m_wbyte, m_field;

  function automatic int width_of(input logic [2:0] c);
    return (c == 0) ? 8 : int'(c);
  endfunction

  function automatic logic [7:0] pick(input logic [7:0] b, input logic [2:0] len, input logic [2:0] pos);
    logic [7:0] r = 0;
    for (int i = 0; i < width_of(len); i++) r[i] = b[(i + 7 - pos) % 8];
    return r;
  endfunction

  function automatic logic [7:0] put(input logic [7:0] b, input logic [7:0] v, input logic [2:0] len, input logic [2:0] pos);
    logic [7:0] r = b;
    for (int i = 0; i < width_of(len); i++)
      if (i + 7 - pos < 8) r[i + 7 - pos] = v[i];
    return r;
  endfunction

  function automatic logic [8:0] m_addr();
    return m_bank ? {1'b1, m_ivr} : {1'b0, m_ivl};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph <= 0; m_ivl <= 0; m_ivr <= 0; m_rdv <= 0; m_wbyte <= 0; m_field <= 0;
      m_bank <= 0; m_wr <= 0; m_len <= 0; m_pos <= 0; m_val <= 0;
    end else begin
      m_rdv <= 0;
      if (ph == 0) begin
        if (req_valid && req_kind == 0) begin
          if (req_bank) m_ivr <= req_data; else m_ivl <= req_data;
        end else if (req_valid && (req_kind == 1 || req_kind == 2)) begin
          ph <= 1; m_bank <= req_bank; m_wr <= (req_kind == 2);
          m_len <= req_len; m_pos <= req_pos; m_val <= req_data;
        end
      end else if (ph == 1) begin
        if (m_wr) begin
          m_wbyte <= put(mem[m_addr()], m_val, m_len, m_pos); ph <= 2;
        end else begin
          m_field <= pick(mem[m_addr()], m_len, m_pos); m_rdv <= 1; ph <= 0;
        end
      end else ph <= 0;
    end
  end

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  bit run_cmp = 0;
  always @(negedge clk) if (run_cmp) begin
    chk("R3/R5 busy", {8'd0, busy}, {8'd0, ph != 0});
    chk("R3 io_rd", {8'd0, io_rd}, {8'd0, ph == 1});
    chk("R5 io_wr", {8'd0, io_wr}, {8'd0, ph == 2});
    chk("R2/R9 io_addr", io_addr, (ph != 0) ? m_addr() : 9'd0);
    if (ph == 2) chk("R6 io_wdata", {1'b0, io_wdata}, {1'b0, m_wbyte});
    chk("R4 rd_valid", {8'd0, rd_valid}, {8'd0, m_rdv});
    if (m_rdv) chk("R4 rd_field", {1'b0, rd_field}, {1'b0, m_field});
  end

  task automatic req(input logic [1:0] k, input logic b, input logic [2:0] l, input logic [2:0] p, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_bank = b; req_len = l; req_pos = p; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37) ^ (i >> 3));
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {8'd0, busy}, 9'd0);
    chk("R1 reset strobes", {7'd0, io_rd, io_wr}, 9'd0);
    chk("R1 reset addr", io_addr, 9'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {6'd0, busy, io_rd, io_wr}, 9'd0);
    run_cmp = 1;
    // directed: addresses, reads, writes, len 0, wrap rotate, truncated merge
    req(0, 0, 0, 0, 8'h12);
    req(0, 1, 0, 0, 8'h34);
    mem[9'h012] = 8'hA5; mem[9'h134] = 8'h3C;
    req(1, 0, 0, 7, 0); repeat (2) @(negedge clk);   // R4 full byte
    req(1, 1, 3, 4, 0); repeat (2) @(negedge clk);   // R4 mid field
    req(1, 0, 5, 1, 0); repeat (2) @(negedge clk);   // R4 wrap
    req(2, 0, 4, 5, 8'h0F); repeat (3) @(negedge clk); // R6
    req(2, 1, 7, 2, 8'h55); repeat (3) @(negedge clk); // R6 truncated mask
    req(2, 1, 0, 7, 8'hC3); repeat (3) @(negedge clk); // R6 whole byte
    req(3, 0, 0, 0, 8'hFF); repeat (2) @(negedge clk); // R8
    req(1, 0, 0, 7, 0); repeat (2) @(negedge clk);   // R8 address unchanged
    // random phase: requests every cycle, many while busy (R7)
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      req_valid = 1'($urandom_range(0, 3) != 0);
      req_kind  = 2'($urandom);
      req_bank  = 1'($urandom);
      req_len   = 3'($urandom);
      req_pos   = 3'($urandom);
      req_data  = 8'($urandom);
    end
    @(negedge clk); req_valid = 0;
    repeat (4) @(negedge clk);
    run_cmp = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule